// File: doc/BRIEF.md
# ADC Channel Conversion Controller

This block sequences conversions of an external analog-to-digital converter on behalf of software. Software selects inputs through byte-wide control registers and sets a run bit. For each conversion the controller then counts a settling interval, a sample delay and a conversion interval. The conversion interval scales with a programmable divider. When the count finishes, the controller captures the 10-bit sample from the converter model into that channel's result registers, sets the channel's valid flag and, if enabled, drives a level interrupt.

One input group of eight channels shares a single control register with a 5-bit selector. Four further channels, numbered 13 to 16, each have their own control and result registers. A summary register collects their valid flags. All timing is counted in strobes of a clock-enable tick, so the intervals scale with the tick rate. While the run bit is set, every enabled channel is converted over and over, taking turns. An optional hold mode keeps a result frozen until software clears its valid flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the shared control register (address 0x02) reads 0x1F, the configuration register (0x00) reads 0x00, the divider register (0x01) reads 0x01, the high-channel summary (0x05) reads 0x00 and `irq_o` is low.
- R2: In the shared control register, bits 4:0 select the input. Codes 0 to 7 request a conversion of that input. Every code from 8 to 0x1F (0x1F being the reset value) requests none, and the field reads back as written.
- R3: With run set (configuration bit 0), one conversion takes SETTLE_TICKS + SAMPLE_TICKS + CONV_UNIT_TICKS × (D+1) tick strobes, where D is the divider field (bits 5:0 of 0x01). A divider of 0 counts as 1. The valid flag is still clear one tick before that total and is set on the last tick.
- R4: A finished conversion stores the converter's 10-bit sample for the converted channel: bits 7:0 in the low result byte and bits 9:8 in bits 1:0 of the high result byte. The shared group uses 0x03 and 0x04. During the conversion `conv_ch_o` carries the input number (0 to 7, or 13 to 16).
- R5: Bit 7 of each control register is the valid flag. It is set on completion. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R6: `irq_o` is high exactly while some channel has both its valid flag and its interrupt enable (control bit 5) set. It falls when the enable or the flag is cleared.
- R7: With hold set (configuration bit 1), a channel whose valid flag is set keeps its result through later conversions until the flag is cleared. With hold clear, each conversion overwrites the result.
- R8: High channel k (0 to 3, input 13+k) has its control register at 0x08+4k, with bit 0 enabling it, and its result bytes at 0x09+4k and 0x0A+4k. Its valid flag also appears at bit k of 0x05.
- R9: Clearing run abandons the conversion in progress without setting any flag. The next conversion after run is set again starts its count from zero.
- R10: While run is set, the enabled channels are converted one at a time in turn, so that with N channels enabled each has completed once after N conversion times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable strobe that paces all intervals |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i`, combinational |
| conv_ch_o | output | 5 | Input number being converted |
| conv_data_i | input | RES_W | Sample from the converter model, captured on completion |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to set up is a completion arriving while a channel's valid flag is still set in hold mode. Without care the data would simply be overwritten and a stale value would never be exposed. The bench pays out tick strobes one at a time, so conversion boundaries fall on exact tick counts. It changes the model's sample offset between two full conversion periods without clearing the flag, and only then clears it and runs a third period. The same tick-exact pacing places a run-bit clear one tick before completion, which shows that the abort discards the partial count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_SAMPLE, PH_CONV} phase_e;

  localparam int CH_W      = 5;
  localparam int NUM_LOW   = 8;
  localparam int HIGH_CH0  = 13;
  localparam int VLD_BIT   = 7;
  localparam int IE_BIT    = 5;
  localparam int HEN_BIT   = 0;
  localparam int RUN_BIT   = 0;
  localparam int HOLD_BIT  = 1;

  localparam int A_CFG     = 0;
  localparam int A_DIV     = 1;
  localparam int A_LCTL    = 2;
  localparam int A_LDL     = 3;
  localparam int A_LDH     = 4;
  localparam int A_HSTS    = 5;
  localparam int A_HBASE   = 8;
  localparam int A_HSTRIDE = 4;
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] settle_len_i,
  input  logic [CNT_W-1:0] sample_len_i,
  input  logic [CNT_W-1:0] conv_len_i,
  output logic             busy_o,
  output logic             done_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, len;
  logic             last;

  always_comb begin
    case (ph_q)
      PH_SETTLE: len = settle_len_i;
      PH_SAMPLE: len = sample_len_i;
      default:   len = conv_len_i;
    endcase
  end

  assign last = tick_i && (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (abort_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start_i) ph_q <= PH_SETTLE;
        end
        default: begin
          if (last) begin
            cnt_q <= '0;
            case (ph_q)
              PH_SETTLE: ph_q <= PH_SAMPLE;
              PH_SAMPLE: ph_q <= PH_CONV;
              default:   ph_q <= PH_IDLE;
            endcase
          end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = (ph_q == PH_CONV) && last && !abort_i;
endmodule

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int NS = 5,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] req_i,
  input  logic          go_i,
  output logic          start_o,
  output logic [SW-1:0] pick_o,
  output logic [SW-1:0] cur_o
);
  logic [SW-1:0] cur_q;
  logic          found;
  int            idx;

  // next requester after the last served slot, wrapping
  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    idx    = 0;
    for (int off = 1; off <= NS; off++) begin
      idx = (int'(cur_q) + off) % NS;
      if (!found && req_i[idx]) begin
        pick_o = SW'(idx);
        found  = 1'b1;
      end
    end
  end

  assign start_o = go_i && (|req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= SW'(NS - 1);
    else if (start_o) cur_q <= pick_o;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/adc_seq_slot.sv
module adc_seq_slot #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic             ie_we_i,
  input  logic             ie_d_i,
  output logic             vld_o,
  output logic             ie_o,
  output logic [RES_W-1:0] data_o
);
  logic             vld_q, ie_q, frozen;
  logic [RES_W-1:0] dat_q;

  assign frozen = hold_i && vld_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ie_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      // completion wins over a simultaneous clear
      if (load_i)      vld_q <= 1'b1;
      else if (clr_i)  vld_q <= 1'b0;
      if (ie_we_i)     ie_q  <= ie_d_i;
      if (load_i && !frozen) dat_q <= data_i;
    end
  end

  assign vld_o  = vld_q;
  assign ie_o   = ie_q;
  assign data_o = dat_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_HIGH        = 4,
  parameter int RES_W           = 10,
  parameter int ADDR_W          = 5,
  parameter int DIV_W           = 6,
  parameter int SETTLE_TICKS    = 2028,
  parameter int SAMPLE_TICKS    = 600,
  parameter int CONV_UNIT_TICKS = 308
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              irq_o
);
  localparam int NS       = NUM_HIGH + 1;
  localparam int SW       = $clog2(NS);
  localparam int PRE_MAX  = (SETTLE_TICKS > SAMPLE_TICKS) ? SETTLE_TICKS : SAMPLE_TICKS;
  localparam int CONV_MAX = CONV_UNIT_TICKS * (1 << DIV_W);
  localparam int MAX_LEN  = (PRE_MAX > CONV_MAX) ? PRE_MAX : CONV_MAX;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  logic                      run_q, hold_q;
  logic [DIV_W-1:0]          div_q, div_eff;
  logic [CH_W-1:0]           low_sel_q, conv_ch_q;
  logic [NUM_HIGH-1:0]       hen_q;
  logic [NS-1:0]             req, vld, ie, load, clr, ie_we, ie_d;
  logic [NS-1:0][RES_W-1:0]  dat;
  logic                      busy, done, start, abort;
  logic [SW-1:0]             pick, cur;
  logic [CNT_W-1:0]          conv_len;
  logic                      wr_cfg, wr_div, wr_lctl;

  assign wr_cfg  = wr_en_i && (addr_i == ADDR_W'(A_CFG));
  assign wr_div  = wr_en_i && (addr_i == ADDR_W'(A_DIV));
  assign wr_lctl = wr_en_i && (addr_i == ADDR_W'(A_LCTL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      hold_q    <= 1'b0;
      div_q     <= DIV_W'(1);
      low_sel_q <= '1;
    end else begin
      if (wr_cfg) begin
        run_q  <= wdata_i[RUN_BIT];
        hold_q <= wdata_i[HOLD_BIT];
      end
      if (wr_div)  div_q     <= wdata_i[DIV_W-1:0];
      if (wr_lctl) low_sel_q <= wdata_i[CH_W-1:0];
    end
  end

  assign req[0]   = (low_sel_q < CH_W'(NUM_LOW));
  assign clr[0]   = wr_lctl && wdata_i[VLD_BIT];
  assign ie_we[0] = wr_lctl;
  assign ie_d[0]  = wdata_i[IE_BIT];

  for (genvar k = 0; k < NUM_HIGH; k++) begin : g_high
    localparam int HA = A_HBASE + A_HSTRIDE * k;
    logic wr_h;
    assign wr_h = wr_en_i && (addr_i == ADDR_W'(HA));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   hen_q[k] <= 1'b0;
      else if (wr_h) hen_q[k] <= wdata_i[HEN_BIT];
    end
    assign req[k+1]   = hen_q[k];
    assign clr[k+1]   = wr_h && wdata_i[VLD_BIT];
    assign ie_we[k+1] = wr_h;
    assign ie_d[k+1]  = wdata_i[IE_BIT];
  end

  for (genvar i = 0; i < NS; i++) begin : g_slot
    adc_seq_slot #(.RES_W(RES_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load[i]),
      .data_i  (conv_data_i),
      .hold_i  (hold_q),
      .clr_i   (clr[i]),
      .ie_we_i (ie_we[i]),
      .ie_d_i  (ie_d[i]),
      .vld_o   (vld[i]),
      .ie_o    (ie[i]),
      .data_o  (dat[i])
    );
  end

  adc_seq_arb #(.NS(NS), .SW(SW)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .go_i    (run_q && !busy),
    .start_o (start),
    .pick_o  (pick),
    .cur_o   (cur)
  );

  assign div_eff  = (div_q == '0) ? DIV_W'(1) : div_q;
  assign conv_len = CNT_W'(CONV_UNIT_TICKS * (int'(div_eff) + 1));
  assign abort    = busy && (!run_q || !req[cur]);

  adc_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .start_i      (start),
    .abort_i      (abort),
    .settle_len_i (CNT_W'(SETTLE_TICKS)),
    .sample_len_i (CNT_W'(SAMPLE_TICKS)),
    .conv_len_i   (conv_len),
    .busy_o       (busy),
    .done_o       (done)
  );

  assign load = done ? (NS'(1) << cur) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_ch_q <= '0;
    else if (start) conv_ch_q <= (pick == '0) ? low_sel_q : CH_W'(HIGH_CH0 + int'(pick) - 1);
  end

  assign conv_ch_o = conv_ch_q;
  assign irq_o     = |(vld & ie);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CFG):  rdata_o = {6'b0, hold_q, run_q};
      ADDR_W'(A_DIV):  rdata_o = 8'(div_q);
      ADDR_W'(A_LCTL): rdata_o = {vld[0], 1'b0, ie[0], low_sel_q};
      ADDR_W'(A_LDL):  rdata_o = dat[0][7:0];
      ADDR_W'(A_LDH):  rdata_o = 8'(dat[0] >> 8);
      ADDR_W'(A_HSTS): rdata_o = 8'(vld[NS-1:1]);
      default: begin
        for (int k = 0; k < NUM_HIGH; k++) begin
          if (addr_i == ADDR_W'(A_HBASE + A_HSTRIDE * k))
            rdata_o = {vld[k+1], 1'b0, ie[k+1], 4'b0, hen_q[k]};
          if (addr_i == ADDR_W'(A_HBASE + A_HSTRIDE * k + 1))
            rdata_o = dat[k+1][7:0];
          if (addr_i == ADDR_W'(A_HBASE + A_HSTRIDE * k + 2))
            rdata_o = 8'(dat[k+1] >> 8);
        end
      end
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NS    = 5,
  parameter int RES_W = 10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     run_i,
  input logic                     busy_i,
  input logic                     hold_i,
  input logic [NS-1:0]            load_i,
  input logic [NS-1:0]            vld_i,
  input logic [NS-1:0]            clr_i,
  input logic [NS-1:0][RES_W-1:0] dat_i
);
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !busy_i) else $error("run clear left timer busy"); // R9

  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_i)) else $error("several slots loaded at once"); // R10

  for (genvar i = 0; i < NS; i++) begin : g_chk
    AST_VALID_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(vld_i[i]) |-> $past(load_i[i])) else $error("valid set without completion"); // R5

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && vld_i[i] && !clr_i[i]) |=> $stable(dat_i[i])) else $error("held result changed"); // R7
  end
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NS(NS), .RES_W(RES_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_q),
  .busy_i (busy),
  .hold_i (hold_q),
  .load_i (load),
  .vld_i  (vld),
  .clr_i  (clr),
  .dat_i  (dat)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int ST = 3, SP = 2, CU = 2;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [4:0] conv_ch;
  logic [9:0] conv_data, base = '0;
  logic       irq;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  function automatic logic [9:0] mdl(int ch, int b);
    return 10'((ch * 37 + b) & 1023);
  endfunction

  function automatic int tconv(int d);
    return ST + SP + CU * (((d == 0) ? 1 : d) + 1);
  endfunction

  assign conv_data = mdl(int'(conv_ch), int'(base));

  adc_seq_ctrl #(
    .SETTLE_TICKS(ST), .SAMPLE_TICKS(SP), .CONV_UNIT_TICKS(CU)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .conv_ch_o(conv_ch),
    .conv_data_i(conv_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = 5'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 5'(a); #1 d = int'(rdata);
  endtask

  task automatic tk(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int d, t, dv, cnt, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2, d); chk("R1 lctl", d, 8'h1F);
    rd(0, d); chk("R1 cfg", d, 0);
    rd(1, d); chk("R1 div", d, 1);
    rd(5, d); chk("R1 hsts", d, 0);
    chk("R1 irq", int'(irq), 0);

    // R3/R4/R5/R6 sweep over low inputs and divider values
    for (int i = 0; i < 8; i++) begin
      dv = i % 5;
      t  = tconv(dv);
      wr(0, 0); wr(1, dv); wr(2, 8'hA0 | i);
      base = 10'(i * 50 + 3);
      wr(0, 1);
      tk(t - 1);
      rd(2, d); chk("R3 valid early", (d >> 7) & 1, 0);
      chk("R6 irq early", int'(irq), 0);
      tk(1);
      rd(2, d); chk("R3 valid on time", (d >> 7) & 1, 1);
      chk("R6 irq set", int'(irq), 1);
      e = int'(mdl(i, int'(base)));
      rd(3, d); chk("R4 low byte", d, e & 8'hFF);
      rd(4, d); chk("R4 high byte", d, e >> 8);
      wr(2, i);
      rd(2, d); chk("R5 write 0 keeps valid", (d >> 7) & 1, 1);
      chk("R6 irq off with enable", int'(irq), 0);
      wr(2, 8'h80 | i);
      rd(2, d); chk("R5 w1c", (d >> 7) & 1, 0);
    end

    // R7 hold
    wr(0, 0); wr(1, 1); wr(2, 8'h82);
    t = tconv(1);
    base = 10'd100; wr(0, 3); tk(t);
    e = int'(mdl(2, 100));
    rd(3, d); chk("R7 first result", d, e & 8'hFF);
    base = 10'd200; tk(t);
    rd(2, d); chk("R7 valid kept", (d >> 7) & 1, 1);
    rd(3, d); chk("R7 frozen low", d, e & 8'hFF);
    rd(4, d); chk("R7 frozen high", d, e >> 8);
    wr(2, 8'h82); tk(t);
    e = int'(mdl(2, 200));
    rd(3, d); chk("R7 after clear low", d, e & 8'hFF);
    rd(4, d); chk("R7 after clear high", d, e >> 8);
    wr(0, 1); base = 10'd300; tk(t);
    e = int'(mdl(2, 300));
    rd(3, d); chk("R7 no hold overwrite", d, e & 8'hFF);

    // R2 disabled selector codes
    wr(0, 0); wr(2, 8'h9F); wr(0, 1); tk(2 * t);
    rd(2, d); chk("R2 code 1F", d, 8'h1F);
    wr(0, 0); wr(2, 8'h89); wr(0, 1); tk(2 * t);
    rd(2, d); chk("R2 code 09", d, 8'h09);
    chk("R2 irq", int'(irq), 0);

    // R8 high channels one by one
    for (int k = 0; k < 4; k++) begin
      wr(0, 0); wr(2, 8'h9F);
      for (int j = 0; j < 4; j++) wr(8 + 4 * j, 8'h80);
      wr(8 + 4 * k, 8'hA1);
      base = 10'(k * 7 + 500);
      wr(0, 1); tk(t);
      rd(5, d); chk("R8 summary", d, 1 << k);
      rd(8 + 4 * k, d); chk("R8 ctl", d, 8'hA1);
      chk("R6 irq high", int'(irq), 1);
      e = int'(mdl(13 + k, int'(base)));
      rd(9 + 4 * k, d); chk("R8 low byte", d, e & 8'hFF);
      rd(10 + 4 * k, d); chk("R8 high byte", d, e >> 8);
    end

    // R10 turn-taking among three channels
    wr(0, 0);
    for (int j = 0; j < 4; j++) wr(8 + 4 * j, 8'h80);
    wr(2, 8'h85); wr(8, 8'h81); wr(16, 8'h81);
    wr(0, 1);
    for (int n = 1; n <= 3; n++) begin
      tk(t);
      rd(2, d); cnt = (d >> 7) & 1;
      rd(5, d); cnt += $countones(d);
      chk("R10 completed count", cnt, n);
    end

    // R9 stop and restart
    wr(0, 0);
    for (int j = 0; j < 4; j++) wr(8 + 4 * j, 8'h80);
    wr(2, 8'h84); wr(0, 1);
    tk(t - 1); wr(0, 0); tk(1);
    rd(2, d); chk("R9 abort no valid", (d >> 7) & 1, 0);
    wr(0, 1); tk(t - 1);
    rd(2, d); chk("R9 restart from zero", (d >> 7) & 1, 0);
    tk(1);
    rd(2, d); chk("R9 restart completes", (d >> 7) & 1, 1);

    summary();
  end
endmodule